// File: doc/BRIEF.md
# Scrambled AMI Burst Line Codec

This block turns a 36-bit parallel payload into one burst of ternary line symbols and recovers payload words from a received symbol stream. A burst opens with an unscrambled start mark. After it come the 36 payload bits, most significant bit first. Each payload bit passes through a self-synchronizing x^9+x^5+1 scrambler. The scrambled bits are then coded with alternate mark inversion: a one becomes a mark whose polarity is the opposite of the previous mark, and a zero becomes the zero level.

The receive side waits for any mark while idle and takes it as the start mark. It then descrambles the next 36 symbols with the same polynomial and presents the word with a one-cycle strobe. It also records any two successive received marks that share a polarity in a sticky flag. Both directions move one symbol per cycle in which `sym_en_i` is high, so a symbol-rate enable from the surrounding burst timing paces the block. Symbols arrive already sliced and sampled.

Top module: `ami_burst_codec`

## Requirements
- R1: Symbols use a two-bit code: 2'b01 is a positive mark, 2'b11 a negative mark and 2'b00 the zero level. The transmitter never emits 2'b10, and the receiver treats a received 2'b10 as the zero level.
- R2: A `tx_start_i` pulse while idle loads `tx_payload_i`. The next 37 enabled cycles emit the burst on `tx_sym_o`, one symbol per enable: the start mark first, then payload bits 35 down to 0. `tx_busy_o` is high from the cycle after the start pulse through the 37th symbol. On an enable while idle, `tx_sym_o` shows the zero level.
- R3: The start mark is never scrambled, and its polarity is the opposite of the last mark sent before it. The first mark after reset is positive.
- R4: Each payload bit d is sent as s = d ^ s(t-5) ^ s(t-9), where s(t-k) is the scrambled bit sent k payload bits earlier. The scrambler history resets to all ones and advances only on payload bits, carrying over from one burst to the next. A scrambled one is a mark of the opposite polarity to the previous mark, and a scrambled zero is the zero level.
- R5: A `tx_start_i` pulse while a burst is in progress is ignored, and the burst in flight completes unchanged.
- R6: While idle, the receiver takes the first received mark as a start mark. It descrambles the next 36 enabled symbols as d = s ^ s(t-5) ^ s(t-9), with the same all-ones reset and payload-only update. After the 36th symbol it pulses `rx_done_o` for one cycle, with `rx_payload_o` holding the word and the first received payload bit at bit 35.
- R7: `viol_o` is set when a received mark has the same polarity as the previous received mark, starting from the second mark after reset. It then stays set.
- R8: `viol_clr_i` clears `viol_o`. A violation detected in the same cycle as a clear leaves the flag set.
- R9: After reset, `tx_sym_o` is zero and `tx_busy_o`, `rx_done_o` and `viol_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_en_i | input | 1 | Symbol-rate enable, one symbol per high cycle |
| tx_start_i | input | 1 | Starts a burst when the transmitter is idle |
| tx_payload_i | input | 36 | Payload word, sampled on an accepted start |
| tx_busy_o | output | 1 | Burst in progress |
| tx_sym_o | output | 2 | Transmitted line symbol |
| rx_sym_i | input | 2 | Received line symbol |
| rx_done_o | output | 1 | One-cycle strobe: received word valid |
| rx_payload_o | output | 36 | Last received payload word |
| viol_clr_i | input | 1 | Clears the violation flag |
| viol_o | output | 1 | Sticky coding-violation flag |

## Verification
Two collisions are provoked on purpose. In the first, the violation flag is cleared in the same enabled cycle that a repeated-polarity mark arrives. The flag must still read set afterwards, and a later clear with no mark must drop it. In the second, a new start pulse arrives in the middle of a burst carrying the inverted payload. The symbol stream is compared with a model of the original payload, and the looped-back received word must equal that original.

// File: rtl/ami_pkg.sv
package ami_pkg;
  localparam logic [1:0] SYM_ZERO = 2'b00;
  localparam logic [1:0] SYM_POS  = 2'b01;
  localparam logic [1:0] SYM_NEG  = 2'b11;

  function automatic logic sym_is_mark(input logic [1:0] s);
    return (s == SYM_POS) || (s == SYM_NEG);
  endfunction

  function automatic logic [1:0] sym_enc(input logic pos);
    return pos ? SYM_POS : SYM_NEG;
  endfunction
endpackage

// File: rtl/ami_scrambler.sv
module ami_scrambler #(
  parameter int W     = 9,
  parameter int TAP   = 5,
  parameter bit DESCR = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  output logic bit_o
);
  logic [W-1:0] sr_q;
  logic         hist_bit;

  assign bit_o = bit_i ^ sr_q[TAP-1] ^ sr_q[W-1];

  // history always holds line-side (scrambled) bits
  generate
    if (DESCR) begin : g_descr
      assign hist_bit = bit_i;
    end else begin : g_scr
      assign hist_bit = bit_o;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sr_q <= '1;
    else if (en_i) sr_q <= {sr_q[W-2:0], hist_bit};
  end
endmodule

// File: rtl/ami_tx.sv
module ami_tx
  import ami_pkg::*;
#(
  parameter int PAYLOAD_W = 36,
  parameter int LFSR_W    = 9,
  parameter int LFSR_TAP  = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sym_en_i,
  input  logic                 start_i,
  input  logic [PAYLOAD_W-1:0] payload_i,
  output logic                 busy_o,
  output logic [1:0]           sym_o
);
  localparam int CNT_W = $clog2(PAYLOAD_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PAYLOAD_W);

  logic [PAYLOAD_W-1:0] data_q;
  logic [CNT_W-1:0]     idx_q;
  logic                 busy_q, last_pos_q;
  logic [1:0]           sym_q;
  logic                 scr_en, scr_bit, line_bit;

  assign scr_en   = sym_en_i && busy_q && (idx_q != '0);
  assign line_bit = (idx_q == '0) ? 1'b1 : scr_bit;

  ami_scrambler #(.W(LFSR_W), .TAP(LFSR_TAP), .DESCR(1'b0)) u_scr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (scr_en),
    .bit_i (data_q[PAYLOAD_W-1]),
    .bit_o (scr_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q     <= '0;
      idx_q      <= '0;
      busy_q     <= 1'b0;
      last_pos_q <= 1'b0;
      sym_q      <= SYM_ZERO;
    end else if (start_i && !busy_q) begin
      data_q <= payload_i;
      idx_q  <= '0;
      busy_q <= 1'b1;
      if (sym_en_i) sym_q <= SYM_ZERO;
    end else if (sym_en_i) begin
      if (!busy_q) begin
        sym_q <= SYM_ZERO;
      end else begin
        if (line_bit) begin
          sym_q      <= sym_enc(!last_pos_q);
          last_pos_q <= !last_pos_q;
        end else begin
          sym_q <= SYM_ZERO;
        end
        if (idx_q != '0) data_q <= {data_q[PAYLOAD_W-2:0], 1'b0};
        idx_q <= idx_q + 1'b1;
        if (idx_q == LAST_IDX) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign sym_o  = sym_q;

  a_r1_no_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_q != 2'b10);
  a_r3_start_is_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_en_i && busy_q && idx_q == '0) |=> sym_is_mark(sym_q));
  a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_en_i && !busy_q && !start_i) |=> sym_q == SYM_ZERO);
  a_r5_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !sym_en_i) |=> ($stable(idx_q) && $stable(data_q)));
endmodule

// File: rtl/ami_rx.sv
module ami_rx
  import ami_pkg::*;
#(
  parameter int PAYLOAD_W = 36,
  parameter int LFSR_W    = 9,
  parameter int LFSR_TAP  = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sym_en_i,
  input  logic [1:0]           sym_i,
  input  logic                 viol_clr_i,
  output logic                 done_o,
  output logic [PAYLOAD_W-1:0] payload_o,
  output logic                 viol_o
);
  localparam int CNT_W = $clog2(PAYLOAD_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PAYLOAD_W - 1);

  logic                 act_q, seen_q, last_pos_q, done_q, viol_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [PAYLOAD_W-1:0] word_q, out_q;
  logic                 mark, pos, viol_set, dscr_bit;

  assign mark     = sym_is_mark(sym_i);
  assign pos      = (sym_i == SYM_POS);
  assign viol_set = sym_en_i && mark && seen_q && (pos == last_pos_q);

  ami_scrambler #(.W(LFSR_W), .TAP(LFSR_TAP), .DESCR(1'b1)) u_dscr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (sym_en_i && act_q),
    .bit_i (mark),
    .bit_o (dscr_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      seen_q     <= 1'b0;
      last_pos_q <= 1'b0;
      cnt_q      <= '0;
      word_q     <= '0;
      out_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (sym_en_i) begin
        if (mark) begin
          last_pos_q <= pos;
          seen_q     <= 1'b1;
        end
        if (!act_q) begin
          if (mark) begin
            act_q <= 1'b1;
            cnt_q <= '0;
          end
        end else begin
          word_q <= {word_q[PAYLOAD_W-2:0], dscr_bit};
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == LAST_IDX) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
            out_q  <= {word_q[PAYLOAD_W-2:0], dscr_bit};
          end
        end
      end
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         viol_q <= 1'b0;
    else if (viol_set)   viol_q <= 1'b1;
    else if (viol_clr_i) viol_q <= 1'b0;
  end

  assign done_o    = done_q;
  assign payload_o = out_q;
  assign viol_o    = viol_q;

  a_r6_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_q && !viol_clr_i) |=> viol_q);
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_set |=> viol_q);
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_clr_i && !viol_set) |=> !viol_q);
endmodule

// File: rtl/ami_burst_codec.sv
module ami_burst_codec #(
  parameter int PAYLOAD_W = 36,
  parameter int LFSR_W    = 9,
  parameter int LFSR_TAP  = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sym_en_i,
  input  logic                 tx_start_i,
  input  logic [PAYLOAD_W-1:0] tx_payload_i,
  output logic                 tx_busy_o,
  output logic [1:0]           tx_sym_o,
  input  logic [1:0]           rx_sym_i,
  output logic                 rx_done_o,
  output logic [PAYLOAD_W-1:0] rx_payload_o,
  input  logic                 viol_clr_i,
  output logic                 viol_o
);
  ami_tx #(.PAYLOAD_W(PAYLOAD_W), .LFSR_W(LFSR_W), .LFSR_TAP(LFSR_TAP)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sym_en_i (sym_en_i),
    .start_i  (tx_start_i),
    .payload_i(tx_payload_i),
    .busy_o   (tx_busy_o),
    .sym_o    (tx_sym_o)
  );

  ami_rx #(.PAYLOAD_W(PAYLOAD_W), .LFSR_W(LFSR_W), .LFSR_TAP(LFSR_TAP)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sym_en_i  (sym_en_i),
    .sym_i     (rx_sym_i),
    .viol_clr_i(viol_clr_i),
    .done_o    (rx_done_o),
    .payload_o (rx_payload_o),
    .viol_o    (viol_o)
  );
endmodule

// File: tb/ami_burst_codec_bench.sv
module ami_burst_codec_bench;
  localparam int N_VEC = 6;
  localparam logic [35:0] VEC_P [N_VEC] = '{
    36'h000000000, 36'hFFFFFFFFF, 36'hA5A5A5A5A,
    36'h123456789, 36'h800000001, 36'hF0F0F0F0F };
  // cycle of a mid-burst start pulse, 99 = none
  localparam int VEC_INJ [N_VEC] = '{99, 99, 10, 99, 0, 99};

  logic clk = 1'b0, rst_n = 1'b0;
  logic sym_en = 1'b0, tx_start = 1'b0, viol_clr = 1'b0, loop = 1'b1;
  logic [35:0] tx_payload = '0;
  logic [1:0]  rx_drv = 2'b00;
  logic tx_busy, rx_done, viol;
  logic [1:0] tx_sym, rx_sym;
  logic [35:0] rx_payload;
  int checks = 0, errors = 0;
  logic [8:0] m_sr = 9'h1FF;
  logic m_pos = 1'b0;  // polarity of last mark sent, 1 = positive

  always #5 clk = ~clk;
  assign rx_sym = loop ? tx_sym : rx_drv;

  ami_burst_codec u_ami_burst_codec (
    .clk_i(clk), .rst_ni(rst_n), .sym_en_i(sym_en), .tx_start_i(tx_start),
    .tx_payload_i(tx_payload), .tx_busy_o(tx_busy), .tx_sym_o(tx_sym),
    .rx_sym_i(rx_sym), .rx_done_o(rx_done), .rx_payload_o(rx_payload),
    .viol_clr_i(viol_clr), .viol_o(viol));

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [1:0] s, input logic clr);
    @(negedge clk);
    sym_en = 1'b1; rx_drv = s; viol_clr = clr;
    @(negedge clk);
    sym_en = 1'b0; viol_clr = 1'b0;
  endtask

  task automatic pulse_start(input logic [35:0] p);
    @(negedge clk);
    tx_start = 1'b1; tx_payload = p;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  task automatic run_burst(input logic [35:0] p, input int inj, input bit first);
    logic [1:0] exp_sym [37];
    logic s;
    m_pos = !m_pos;
    exp_sym[0] = m_pos ? 2'b01 : 2'b11;
    for (int i = 0; i < 36; i++) begin
      s = p[35-i] ^ m_sr[4] ^ m_sr[8];
      m_sr = {m_sr[7:0], s};
      if (s) begin m_pos = !m_pos; exp_sym[i+1] = m_pos ? 2'b01 : 2'b11; end
      else exp_sym[i+1] = 2'b00;
    end
    pulse_start(p);
    for (int k = 0; k < 37; k++) begin
      if (k == inj) pulse_start(~p);  // R5: must be ignored
      tick(2'b00, 1'b0);
      check(tx_sym == exp_sym[k], (k == 0) ? "R3 start mark" : "R4 scrambled symbol",
            36'(tx_sym), 36'(exp_sym[k]));
      if (first && k == 0) check(tx_sym == 2'b01, "R3 first mark positive", 36'(tx_sym), 36'h1);
      check(tx_busy == (k < 36), "R2 busy", 36'(tx_busy), 36'(k < 36));
    end
    tick(2'b00, 1'b0);
    check(tx_sym == 2'b00, "R2 idle zero", 36'(tx_sym), 36'h0);
    check(rx_done == 1'b1, "R6 done strobe", 36'(rx_done), 36'h1);
    check(rx_payload == p, (inj != 99) ? "R5 payload kept" : "R6 payload", rx_payload, p);
    check(viol == 1'b0, "R7 no violation", 36'(viol), 36'h0);
    @(negedge clk);
    check(rx_done == 1'b0, "R6 strobe one cycle", 36'(rx_done), 36'h0);
  endtask

  task automatic feed_zeros(output logic [35:0] exp);
    exp = '0;
    for (int i = 0; i < 36; i++) begin
      exp = {exp[34:0], m_sr[4] ^ m_sr[8]};
      m_sr = {m_sr[7:0], 1'b0};
      tick(2'b00, 1'b0);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [35:0] exp;
    logic [1:0] rep;
    bit any_done;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(tx_sym == 2'b00, "R9 tx_sym", 36'(tx_sym), 36'h0);
    check(tx_busy == 1'b0, "R9 busy", 36'(tx_busy), 36'h0);
    check(rx_done == 1'b0, "R9 done", 36'(rx_done), 36'h0);
    check(viol == 1'b0, "R9 viol", 36'(viol), 36'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < N_VEC; v++) run_burst(VEC_P[v], VEC_INJ[v], v == 0);

    // R1: code 2'b10 on an idle receiver is the zero level
    loop = 1'b0;
    any_done = 1'b0;
    tick(2'b10, 1'b0);
    for (int i = 0; i < 37; i++) begin
      tick(2'b00, 1'b0);
      if (rx_done) any_done = 1'b1;
    end
    check(!any_done, "R1 2'b10 not a mark", 36'(any_done), 36'h0);
    check(viol == 1'b0, "R1 2'b10 no violation", 36'(viol), 36'h0);

    // R7: repeated polarity, then a burst of zeros
    rep = m_pos ? 2'b01 : 2'b11;
    tick(rep, 1'b0);
    check(viol == 1'b1, "R7 violation set", 36'(viol), 36'h1);
    feed_zeros(exp);
    check(rx_done == 1'b1, "R6 injected done", 36'(rx_done), 36'h1);
    check(rx_payload == exp, "R6 injected payload", rx_payload, exp);
    check(viol == 1'b1, "R7 sticky", 36'(viol), 36'h1);

    // R8: clear and violation in the same cycle
    tick(rep, 1'b1);
    check(viol == 1'b1, "R8 set wins", 36'(viol), 36'h1);
    feed_zeros(exp);
    check(rx_payload == exp, "R6 second injected payload", rx_payload, exp);
    tick(2'b00, 1'b1);
    check(viol == 1'b0, "R8 clear", 36'(viol), 36'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule